// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block connects a synchronous request port to an external asynchronous static RAM of 128K words by 16 bits. The RAM has active-low chip, write and output enables and a separate active-low enable for each byte lane. A requester presents an address, write data, a two-bit lane mask and a read or write command. The block runs one access at a time and ends each access with a single-cycle done pulse. For a read, the returned data comes with that pulse.

The memory bus is split into a data-out vector, a drive-enable and a data-in vector, so the tristate buffer sits at the pad. Every interval in the access is an integer number of clock cycles. Each count is computed from a nanosecond figure and the clock period: the read window, the write pulse, the data setup and the bus release time. Each access starts with a setup cycle in which the new address is presented while every strobe is idle. Writes keep the output enable high, and the block turns its own drivers on only after the write enable has been low long enough for the memory to release the bus.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, every memory strobe is high, the drive-enable is 0, done is 0 and ready is 1.
- R2: The memory address changes only in a cycle in which chip, write and both lane enables are high, and were also high in the cycle before. Every access begins with exactly one setup cycle: the address is presented and all strobes are high.
- R3: A read holds chip enable and output enable low and write enable high for RD_CYC cycles. The lower-lane enable is low exactly when mask bit 0 is 1, and the upper-lane enable is low exactly when mask bit 1 is 1.
- R4: Read data is taken from the bus in the last read cycle. Done is raised in the next cycle, with bits 7:0 holding the lower lane and bits 15:8 the upper lane. A lane whose mask bit is 0 returns zero.
- R5: A write holds chip enable and write enable low and output enable high for WR_CYC cycles, with the lane enables set from the mask as in R3. Only lanes whose mask bit is 1 change in memory.
- R6: In a write, the drive-enable rises HZ_CYC cycles after write enable falls. It stays high through the one all-idle recovery cycle after write enable rises. It is never high while output enable is low.
- R7: Done is high for one cycle per request and only while ready is high. Ready is high only when the block is idle. A new request is accepted in the cycle that carries done.
- R8: A request with mask 00 never lowers chip enable, leaves memory unchanged, and raises done in the cycle after it is accepted.
- R9: Each count is ceil(time_ns / CLK_NS) with a minimum of 1. WR_CYC is the larger of the write-pulse count and HZ_CYC plus the data-setup count. With the default parameters, RD_CYC = 2, HZ_CYC = 1 and WR_CYC = 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; taken when ready is high |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane mask: bit 0 lower byte, bit 1 upper byte |
| req_ready | output | 1 | Block idle, request can be taken |
| rsp_rdata | output | 16 | Read data, valid with done after a read |
| rsp_done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 17 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Lower-lane enable, active low |
| mem_ub_n | output | 1 | Upper-lane enable, active low |
| mem_dq_out | output | 16 | Data driven toward memory |
| mem_dq_oe | output | 1 | Drive-enable for mem_dq_out |
| mem_dq_in | input | 16 | Data received from memory |

## Verification
Some rules are checked on every cycle by the assertions:
- the address holds while any strobe is active,
- output enable and the drive-enable never overlap,
- drive starts only after write enable is already low,
- write and read strobe sets stay consistent,
- a zero-mask request keeps chip enable high.

Other behaviour appears only in the bench scenarios, where a behavioural memory and an expected-cycle queue are compared on every clock:
- the exact cycle lengths of the read and write windows,
- lane masking of read data,
- partial-lane writes that leave the other byte intact,
- back-to-back acceptance in the done cycle.

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
  parameter int AW      = 17,
  parameter int DW      = 16,
  parameter int CLK_NS  = 5,
  parameter int T_RC_NS = 10,
  parameter int T_WP_NS = 8,
  parameter int T_DS_NS = 6,
  parameter int T_HZ_NS = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_be,
  output logic          req_ready,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_done,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic          mem_lb_n,
  output logic          mem_ub_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);

  function automatic int ns2cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  // R9
  localparam int RD_CYC = ns2cyc(T_RC_NS);
  localparam int WP_CYC = ns2cyc(T_WP_NS);
  localparam int DS_CYC = ns2cyc(T_DS_NS);
  localparam int HZ_CYC = ns2cyc(T_HZ_NS);
  localparam int WR_CYC = (WP_CYC > HZ_CYC + DS_CYC) ? WP_CYC : HZ_CYC + DS_CYC;
  localparam int MAXC   = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
  localparam int CW     = $clog2(MAXC + 1);
  localparam int HB     = DW / 2;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_READ, S_WRITE, S_REC} st_t;

  st_t           st, nx;
  logic [CW-1:0] cnt, cnt_nx;
  logic          we_q;
  logic [1:0]    be_q;

  wire accept   = (st == S_IDLE) && req_valid;
  wire null_req = accept && (req_be == 2'b00);
  wire last_rd  = (st == S_READ)  && (cnt == CW'(RD_CYC - 1));
  wire last_wr  = (st == S_WRITE) && (cnt == CW'(WR_CYC - 1));
  wire nx_act   = (nx == S_READ) || (nx == S_WRITE);

  assign req_ready = (st == S_IDLE);

  always_comb begin
    nx = st;
    unique case (st)
      S_IDLE:  if (accept && !null_req) nx = S_SETUP;
      S_SETUP: nx = we_q ? S_WRITE : S_READ;
      S_READ:  if (last_rd) nx = S_IDLE;
      S_WRITE: if (last_wr) nx = S_REC;
      S_REC:   nx = S_IDLE;
      default: nx = S_IDLE;
    endcase
    cnt_nx = (nx == st && (st == S_READ || st == S_WRITE)) ? cnt + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      we_q       <= 1'b0;
      be_q       <= 2'b00;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      mem_ce_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_lb_n   <= 1'b1;
      mem_ub_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
      rsp_done   <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      st  <= nx;
      cnt <= cnt_nx;
      if (accept && !null_req) begin
        we_q       <= req_we;
        be_q       <= req_be;
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
      mem_ce_n  <= !nx_act;
      mem_we_n  <= !(nx == S_WRITE);
      mem_oe_n  <= !(nx == S_READ);
      mem_lb_n  <= !(nx_act && be_q[0]);
      mem_ub_n  <= !(nx_act && be_q[1]);
      mem_dq_oe <= ((nx == S_WRITE) && (cnt_nx >= CW'(HZ_CYC))) || (nx == S_REC);
      rsp_done  <= last_rd || (st == S_REC) || null_req;
      if (last_rd)
        rsp_rdata <= {be_q[1] ? mem_dq_in[DW-1:HB] : {(DW-HB){1'b0}},
                      be_q[0] ? mem_dq_in[HB-1:0]  : {HB{1'b0}}};
    end
  end

  wire all_idle = mem_ce_n && mem_we_n && mem_lb_n && mem_ub_n;

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!all_idle || !$past(all_idle)) |-> $stable(mem_addr));

  // R6
  drive_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  // R6
  drive_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (!mem_we_n && $past(!mem_we_n)));

  // R5
  write_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && !mem_ce_n && !(mem_lb_n && mem_ub_n)));

  // R3
  read_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n && !(mem_lb_n && mem_ub_n)));

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> req_ready);

  // R8
  null_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_be == 2'b00) |=> (mem_ce_n && rsp_done));

endmodule

// File: tb/tb_sram_lane_ctrl.sv
module tb_sram_lane_ctrl;
  localparam int CLK_NS = 5;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int RDC = cyc(10);
  localparam int WPC = cyc(8);
  localparam int DSC = cyc(6);
  localparam int HZC = cyc(5);
  localparam int WLC = (WPC > HZC + DSC) ? WPC : HZC + DSC;
  localparam logic [6:0] IDLE_V = 7'b1111100;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_we = 0;
  logic [16:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0] req_be = '0;
  logic req_ready, rsp_done, mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;
  logic [15:0] rsp_rdata, mem_dq_out, mem_dq_in;
  logic [16:0] mem_addr;

  always #2.5 clk = ~clk;

  sram_lane_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .req_ready(req_ready), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  // behavioural memory on the bus side, and request-side expectation
  logic [15:0] ram [64];
  logic [15:0] refm [64];
  initial for (int i = 0; i < 64; i++) begin ram[i] = '0; refm[i] = '0; end

  wire rd_on = !mem_ce_n && !mem_oe_n && mem_we_n;
  always_comb begin
    mem_dq_in[7:0]  = (rd_on && !mem_lb_n) ? ram[mem_addr[5:0]][7:0]  : 8'h5A;
    mem_dq_in[15:8] = (rd_on && !mem_ub_n) ? ram[mem_addr[5:0]][15:8] : 8'hA5;
  end

  always @(posedge clk) begin
    if (!mem_ce_n && !mem_we_n && mem_dq_oe) begin
      if (!mem_lb_n) ram[mem_addr[5:0]][7:0]  <= mem_dq_out[7:0];
      if (!mem_ub_n) ram[mem_addr[5:0]][15:8] <= mem_dq_out[15:8];
    end
  end

  typedef struct {
    logic [6:0]  v;
    logic        ca;
    logic [16:0] a;
    logic        cr;
    logic [15:0] rd;
    string       tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_bad = 0, cycles = 0;
  logic run = 0;

  task automatic push(input logic [6:0] v, input logic ca, input logic [16:0] a,
                      input logic cr, input logic [15:0] rd, input string tag);
    exp_t e;
    e.v = v; e.ca = ca; e.a = a; e.cr = cr; e.rd = rd; e.tag = tag;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (run) begin
      exp_t e;
      logic [6:0] got;
      if (q.size() > 0) e = q.pop_front();
      else begin
        e.v = IDLE_V; e.ca = 0; e.a = '0; e.cr = 0; e.rd = '0; e.tag = "R1 R7";
      end
      got = {mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe, rsp_done};
      n_chk++;
      if (got !== e.v) begin
        n_bad++;
        $display("FAIL %s strobes{ce,we,oe,lb,ub,oe_d,done} got %b exp %b", e.tag, got, e.v);
      end
      if (e.ca) begin
        n_chk++;
        if (mem_addr !== e.a) begin
          n_bad++;
          $display("FAIL R2 addr got %h exp %h", mem_addr, e.a);
        end
      end
      if (e.cr) begin
        n_chk++;
        if (rsp_rdata !== e.rd) begin
          n_bad++;
          $display("FAIL R4 rdata got %h exp %h", rsp_rdata, e.rd);
        end
      end
    end
  end

  task automatic issue(input logic w, input logic [16:0] a, input logic [15:0] d,
                       input logic [1:0] be);
    logic lb, ub;
    logic [15:0] exp_rd;
    while (1) begin
      @(posedge clk); #1;
      if (q.size() <= 1) break;
    end
    if (q.size() == 0) push(IDLE_V, 0, '0, 0, '0, "R7");
    req_valid = 1; req_we = w; req_addr = a; req_wdata = d; req_be = be;
    lb = !be[0]; ub = !be[1];
    if (be == 2'b00) begin
      push(7'b1111101, 0, '0, 0, '0, "R8");
    end else begin
      push(IDLE_V, 1, a, 0, '0, "R2");
      if (!w) begin
        exp_rd = {be[1] ? refm[a[5:0]][15:8] : 8'h00, be[0] ? refm[a[5:0]][7:0] : 8'h00};
        for (int i = 0; i < RDC; i++) push({3'b010, lb, ub, 2'b00}, 1, a, 0, '0, "R3");
        push(7'b1111101, 1, a, 1, exp_rd, "R4");
      end else begin
        for (int i = 0; i < WLC; i++)
          push({3'b001, lb, ub, (i >= HZC), 1'b0}, 1, a, 0, '0, "R5 R6");
        push(7'b1111110, 1, a, 0, '0, "R6");
        push(7'b1111101, 1, a, 0, '0, "R7");
        if (be[0]) refm[a[5:0]][7:0]  = d[7:0];
        if (be[1]) refm[a[5:0]][15:8] = d[15:8];
      end
    end
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 20000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    n_chk++;
    if ({mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe, rsp_done} !== IDLE_V) begin
      n_bad++;
      $display("FAIL R1 reset strobes got %b exp %b",
               {mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe, rsp_done}, IDLE_V);
    end
    n_chk++;
    if (req_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL R1 ready got %b exp 1", req_ready);
    end
    // R9: defaults give RD=2, HZ=1, WR=3 cycles
    n_chk++;
    if (RDC != 2 || HZC != 1 || WLC != 3) begin
      n_bad++;
      $display("FAIL R9 counts got %0d/%0d/%0d exp 2/1/3", RDC, HZC, WLC);
    end
    run = 1;
    issue(1, 17'h00001, 16'h1234, 2'b11);
    issue(1, 17'h1FFFF, 16'hABCD, 2'b11);
    issue(0, 17'h00001, 16'h0000, 2'b11);
    issue(1, 17'h00001, 16'h77EE, 2'b01);   // R5 lower lane only
    issue(0, 17'h00001, 16'h0000, 2'b11);
    issue(1, 17'h00001, 16'h9900, 2'b10);   // R5 upper lane only
    issue(0, 17'h00001, 16'h0000, 2'b01);   // R4 upper returns zero
    issue(0, 17'h00001, 16'h0000, 2'b10);   // R4 lower returns zero
    issue(1, 17'h00002, 16'hFFFF, 2'b00);   // R8 null write
    issue(0, 17'h00002, 16'h0000, 2'b11);
    issue(0, 17'h00002, 16'h0000, 2'b00);   // R8 null read
    issue(0, 17'h1FFFF, 16'h0000, 2'b11);
    issue(1, 17'h10000, 16'h5566, 2'b11);
    issue(0, 17'h10000, 16'h0000, 2'b11);   // R7 back-to-back
    issue(0, 17'h00001, 16'h0000, 2'b11);
    repeat (12) @(posedge clk);
    @(negedge clk);
    run = 0;
    // R5 memory contents match request history
    for (int i = 0; i < 64; i++) begin
      n_chk++;
      if (ram[i] !== refm[i]) begin
        n_bad++;
        $display("FAIL R5 mem[%0d] got %h exp %h", i, ram[i], refm[i]);
      end
    end
    finish_run();
  end
endmodule